// File: doc/BRIEF.md
# Dynamic Thread Spawn Scheduler

This block hands out virtual thread IDs to a group of lightweight thread control units (TCUs) when a serial master starts a parallel section over an inclusive ID range. The master presents the lower bound, the upper bound and the start address of the thread code. The scheduler puts the bound and the start address on one shared bus for all TCUs. It gives each TCU its first ID without using the shared counter: TCU i takes lower bound plus i. A TCU that finishes a thread asks for another ID. Requests go through a fetch-and-add on a shared counter, so no ID is issued twice and no work is split up in advance.

A TCU that draws an ID above the bound retires and raises its done flag. Threads never wait for one another. The only synchronisation point is the join. Once every done flag is set, the master sees a one-cycle join pulse and control returns to it.

The controller has four states. ST_IDLE waits for a spawn. Transition T_ACCEPT (spawn_valid in ST_IDLE) goes to ST_BCAST, which drives the broadcast and the initial grants for one cycle. Transition T_LAUNCH always goes to ST_RUN, where requests are served. Transition T_ALL_DONE (every done flag set) goes to ST_JOIN, which drives the join pulse. Transition T_RETURN always goes back to ST_IDLE.

Top module: `spawn_sched`

## Requirements
- R1: A spawn is taken only in the idle state. bcast_valid is high for exactly the one cycle after the spawn is taken, and bcast_hi and bcast_pc carry the spawn's upper bound and code address in that cycle. A spawn presented while a section is active has no effect.
- R2: In the broadcast cycle, every TCU i with lo+i <= hi sees tcu_gnt[i] high and tcu_id slice i (bits i*IDW and up) equal to lo+i.
- R3: A TCU with lo+i > hi gets no grant in the broadcast cycle, and its done flag is high from the next cycle on.
- R4: In the run state, a request from a TCU that is still running is granted in the same cycle. The first ID drawn from the counter is lo+N, where N is the number of TCUs.
- R5: Requests that arrive in the same cycle are all served in that cycle. They get consecutive, distinct IDs, with lower TCU indices taking lower IDs, and the counter then advances by the number of requesters.
- R6: A request whose ID would exceed hi is not granted. That TCU's done flag rises on the next cycle and stays high until the next spawn.
- R7: A request from a TCU whose done flag is set gets no grant and does not advance the counter.
- R8: join_done is high for exactly one cycle. It rises one cycle after the last done flag rises, and it is only ever high while all done flags are high.
- R9: After reset the block is idle: bcast_valid, join_done, all grants and all done flags are low.
- R10: For an empty range (lo > hi), no grant is given. All done flags rise after the broadcast cycle, and join_done follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spawn_valid | input | 1 | Master starts a section |
| spawn_lo | input | IDW | Lowest thread ID of the range |
| spawn_hi | input | IDW | Highest thread ID of the range |
| spawn_pc | input | PCW | Start address of the thread code |
| bcast_valid | output | 1 | Shared-bus broadcast strobe |
| bcast_hi | output | IDW | Broadcast upper bound |
| bcast_pc | output | PCW | Broadcast code address |
| tcu_req | input | N | Per-TCU request for the next ID |
| tcu_gnt | output | N | Per-TCU grant |
| tcu_id | output | N*IDW | Per-TCU granted ID, slice i at bits i*IDW and up |
| tcu_done | output | N | Per-TCU done flag |
| join_done | output | 1 | One-cycle join-complete pulse to the master |

## Verification
Two functions can fall in the same cycle. The fetch-and-add that serves several TCUs at once can coincide with the retirement of a TCU whose drawn ID passes the bound. The bench provokes this by raising all requests together while only some of the drawn IDs still fit in the range. It then checks three things: the in-range TCUs receive consecutive IDs in index order, the others get no grant and raise done on the next cycle, and the join pulse follows exactly one cycle after the last flag rises.

// File: rtl/spawn_sched_pkg.sv
package spawn_sched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BCAST = 2'd1,
        ST_RUN   = 2'd2,
        ST_JOIN  = 2'd3
    } sched_state_t;
endpackage

// File: rtl/spawn_alloc.sv
// Prefix-sum allocator: ranks same-cycle requesters by index and hands out IDs.
module spawn_alloc #(
    parameter int N   = 4,
    parameter int IDW = 8,
    parameter int CW  = 11
) (
    input  logic             bcast,
    input  logic [IDW-1:0]   lo,
    input  logic [IDW-1:0]   hi,
    input  logic [CW-1:0]    cnt,
    input  logic [N-1:0]     req,
    output logic [N*IDW-1:0] id_flat,
    output logic [N-1:0]     ok,
    output logic [CW-1:0]    cnt_next
);
    logic [CW-1:0] cand [N];
    logic [CW-1:0] run_sum [N+1];

    always_comb begin
        run_sum[0] = cnt;
        for (int i = 0; i < N; i++) begin
            cand[i]        = bcast ? (CW'(lo) + CW'(i)) : run_sum[i];
            ok[i]          = (cand[i] <= CW'(hi));
            id_flat[i*IDW +: IDW] = cand[i][IDW-1:0];
            run_sum[i+1]   = run_sum[i] + CW'(req[i]);
        end
        cnt_next = run_sum[N];
    end
endmodule

// File: rtl/tcu_slot.sv
// Per-TCU tracker: running / retired status and grant generation.
module tcu_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    input  logic start_ok,
    input  logic take,
    input  logic take_ok,
    output logic gnt,
    output logic busy,
    output logic done
);
    logic take_live;
    assign take_live = take & busy;
    assign gnt = (start & start_ok) | (take_live & take_ok);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else if (clear) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else if (start) begin
            busy <= start_ok;
            done <= ~start_ok;
        end else if (take_live && !take_ok) begin
            busy <= 1'b0;
            done <= 1'b1;
        end
    end

    p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> done);
endmodule

// File: rtl/spawn_sched.sv
module spawn_sched
    import spawn_sched_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDW = 8,
    parameter int PCW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spawn_valid,
    input  logic [IDW-1:0]   spawn_lo,
    input  logic [IDW-1:0]   spawn_hi,
    input  logic [PCW-1:0]   spawn_pc,
    output logic             bcast_valid,
    output logic [IDW-1:0]   bcast_hi,
    output logic [PCW-1:0]   bcast_pc,
    input  logic [N-1:0]     tcu_req,
    output logic [N-1:0]     tcu_gnt,
    output logic [N*IDW-1:0] tcu_id,
    output logic [N-1:0]     tcu_done,
    output logic             join_done
);
    localparam int CW = IDW + $clog2(N) + 2;

    sched_state_t    state_q, state_d;
    logic [IDW-1:0]  lo_q, hi_q;
    logic [PCW-1:0]  pc_q;
    logic [CW-1:0]   cnt_q, cnt_next;
    logic            accept, in_bcast, in_run;
    logic [N-1:0]    busy, ok, req_eff;

    assign accept   = (state_q == ST_IDLE) && spawn_valid;
    assign in_bcast = (state_q == ST_BCAST);
    assign in_run   = (state_q == ST_RUN);
    assign req_eff  = tcu_req & busy & {N{in_run}};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_BCAST;          // T_ACCEPT
            ST_BCAST: state_d = ST_RUN;                         // T_LAUNCH
            ST_RUN:   if (&tcu_done) state_d = ST_JOIN;         // T_ALL_DONE
            ST_JOIN:  state_d = ST_IDLE;                        // T_RETURN
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath registers: range latch and shared counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            pc_q  <= '0;
            cnt_q <= '0;
        end else if (accept) begin
            lo_q <= spawn_lo;
            hi_q <= spawn_hi;
            pc_q <= spawn_pc;
        end else if (in_bcast) begin
            cnt_q <= CW'(lo_q) + CW'(N);
        end else if (in_run) begin
            cnt_q <= cnt_next;
        end
    end

    // Outputs
    always_comb begin
        bcast_valid = in_bcast;
        bcast_hi    = hi_q;
        bcast_pc    = pc_q;
        join_done   = (state_q == ST_JOIN);
    end

    spawn_alloc #(.N(N), .IDW(IDW), .CW(CW)) u_alloc (
        .bcast    (in_bcast),
        .lo       (lo_q),
        .hi       (hi_q),
        .cnt      (cnt_q),
        .req      (req_eff),
        .id_flat  (tcu_id),
        .ok       (ok),
        .cnt_next (cnt_next)
    );

    for (genvar g = 0; g < N; g++) begin : g_slot
        tcu_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (accept),
            .start    (in_bcast),
            .start_ok (ok[g]),
            .take     (in_run & tcu_req[g]),
            .take_ok  (ok[g]),
            .gnt      (tcu_gnt[g]),
            .busy     (busy[g]),
            .done     (tcu_done[g])
        );
    end

    p_bcast_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |=> !bcast_valid);
    p_join_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        join_done |=> !join_done);
    p_join_all_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        join_done |-> (&tcu_done));
    p_no_gnt_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tcu_gnt & tcu_done) == '0);
    p_cnt_monotonic_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: tb/test_spawn_sched.sv
`timescale 1ns/1ps
module test_spawn_sched;
    localparam int N = 4, IDW = 8, PCW = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             spawn_valid = 1'b0;
    logic [IDW-1:0]   spawn_lo = '0, spawn_hi = '0;
    logic [PCW-1:0]   spawn_pc = '0;
    logic             bcast_valid, join_done;
    logic [IDW-1:0]   bcast_hi;
    logic [PCW-1:0]   bcast_pc;
    logic [N-1:0]     tcu_req = '0, tcu_gnt, tcu_done;
    logic [N*IDW-1:0] tcu_id;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    spawn_sched #(.N(N), .IDW(IDW), .PCW(PCW)) i_spawn_sched (
        .clk(clk), .rst_n(rst_n), .spawn_valid(spawn_valid),
        .spawn_lo(spawn_lo), .spawn_hi(spawn_hi), .spawn_pc(spawn_pc),
        .bcast_valid(bcast_valid), .bcast_hi(bcast_hi), .bcast_pc(bcast_pc),
        .tcu_req(tcu_req), .tcu_gnt(tcu_gnt), .tcu_id(tcu_id),
        .tcu_done(tcu_done), .join_done(join_done)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [IDW-1:0] id_of(input int i);
        return tcu_id[i*IDW +: IDW];
    endfunction

    // advance to next negedge, then settle
    task automatic step();
        @(negedge clk);
        #0.5;
    endtask

    task automatic do_spawn(input logic [IDW-1:0] lo, input logic [IDW-1:0] hi, input logic [PCW-1:0] pc);
        @(negedge clk);
        spawn_valid = 1'b1; spawn_lo = lo; spawn_hi = hi; spawn_pc = pc;
        @(negedge clk);
        spawn_valid = 1'b0;
        #0.5;
    endtask

    task automatic test_reset();
        step();
        chk("R9", "bcast_valid", 32'(bcast_valid), 0);
        chk("R9", "join_done", 32'(join_done), 0);
        chk("R9", "gnt", 32'(tcu_gnt), 0);
        chk("R9", "done", 32'(tcu_done), 0);
    endtask

    task automatic test_full_range();
        do_spawn(8'd10, 8'd20, 16'h0040);
        chk("R1", "bcast_valid", 32'(bcast_valid), 1);
        chk("R1", "bcast_hi", 32'(bcast_hi), 20);
        chk("R1", "bcast_pc", 32'(bcast_pc), 32'h40);
        chk("R2", "initial gnt", 32'(tcu_gnt), 32'hf);
        for (int i = 0; i < N; i++) chk("R2", "initial id", 32'(id_of(i)), 10 + i);
        // run: requests from TCU1 and TCU3; also a spawn attempt that must be ignored
        @(negedge clk);
        tcu_req = 4'b1010; spawn_valid = 1'b1; spawn_lo = 8'd0; spawn_hi = 8'd1; spawn_pc = 16'h9999;
        #0.5;
        chk("R1", "bcast low after broadcast", 32'(bcast_valid), 0);
        chk("R4", "gnt pair", 32'(tcu_gnt), 32'ha);
        chk("R4", "tcu1 first counter id", 32'(id_of(1)), 14);
        chk("R5", "tcu3 id", 32'(id_of(3)), 15);
        @(negedge clk);
        spawn_valid = 1'b0; tcu_req = 4'b1111;
        #0.5;
        chk("R1", "spawn ignored while active", 32'(bcast_valid), 0);
        chk("R5", "all gnt", 32'(tcu_gnt), 32'hf);
        for (int i = 0; i < N; i++) chk("R5", "consecutive id", 32'(id_of(i)), 16 + i);
        @(negedge clk);
        tcu_req = 4'b0001;
        #0.5;
        chk("R5", "last id gnt", 32'(tcu_gnt), 1);
        chk("R5", "last id", 32'(id_of(0)), 20);
        @(negedge clk);
        tcu_req = 4'b1111;
        #0.5;
        chk("R6", "out of range no gnt", 32'(tcu_gnt), 0);
        chk("R6", "done not yet", 32'(tcu_done), 0);
        @(negedge clk);
        tcu_req = 4'b0000;
        #0.5;
        chk("R6", "all done", 32'(tcu_done), 32'hf);
        chk("R8", "join not yet", 32'(join_done), 0);
        step();
        chk("R8", "join pulse", 32'(join_done), 1);
        step();
        chk("R8", "join one cycle", 32'(join_done), 0);
        chk("R6", "done held", 32'(tcu_done), 32'hf);
    endtask

    task automatic test_short_range();
        do_spawn(8'd5, 8'd6, 16'h0100);
        chk("R2", "short gnt", 32'(tcu_gnt), 32'h3);
        chk("R2", "tcu1 id", 32'(id_of(1)), 6);
        chk("R3", "done clear in bcast", 32'(tcu_done), 0);
        @(negedge clk);
        tcu_req = 4'b1100;
        #0.5;
        chk("R3", "spare TCUs done", 32'(tcu_done), 32'hc);
        chk("R7", "retired req no gnt", 32'(tcu_gnt), 0);
        @(negedge clk);
        tcu_req = 4'b0011;
        #0.5;
        // counter untouched by R7 requests: would give 9,10, both above 6
        chk("R6", "exhausted no gnt", 32'(tcu_gnt), 0);
        @(negedge clk);
        tcu_req = 4'b0000;
        #0.5;
        chk("R6", "all done", 32'(tcu_done), 32'hf);
        step();
        chk("R8", "join pulse short", 32'(join_done), 1);
        step();
        chk("R8", "join drop short", 32'(join_done), 0);
    endtask

    task automatic test_counter_skip();
        // R7: requests by retired TCU must not consume IDs
        do_spawn(8'd0, 8'd5, 16'h0200);
        chk("R2", "gnt all", 32'(tcu_gnt), 32'hf);
        @(negedge clk);
        tcu_req = 4'b0100;
        #0.5;
        chk("R4", "tcu2 id", 32'(id_of(2)), 4);
        @(negedge clk);
        tcu_req = 4'b0101;
        #0.5;
        chk("R5", "pair gnt", 32'(tcu_gnt), 32'h1);
        chk("R5", "tcu0 id", 32'(id_of(0)), 5);
        @(negedge clk);
        tcu_req = 4'b1111;
        #0.5;
        chk("R6", "final no gnt", 32'(tcu_gnt), 0);
        @(negedge clk);
        tcu_req = 4'b0000;
        #0.5;
        chk("R6", "all done", 32'(tcu_done), 32'hf);
        step();
        chk("R8", "join", 32'(join_done), 1);
        step();
    endtask

    task automatic test_empty();
        do_spawn(8'd8, 8'd7, 16'h0300);
        chk("R10", "bcast", 32'(bcast_valid), 1);
        chk("R10", "no gnt", 32'(tcu_gnt), 0);
        chk("R3", "done cleared by spawn", 32'(tcu_done), 0);
        step();
        chk("R10", "all done", 32'(tcu_done), 32'hf);
        chk("R10", "join not yet", 32'(join_done), 0);
        step();
        chk("R10", "join", 32'(join_done), 1);
        step();
        chk("R10", "join drop", 32'(join_done), 0);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_full_range();
        test_short_range();
        test_counter_skip();
        test_empty();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule